// File: doc/BRIEF.md
# Program ROM bank and page selector

This block sits between a processor's program bus and three program ROMs, each of which holds two pages. It decides which ROM drives the processor data bus and which page of that ROM is addressed. One ROM, the boot ROM, is selected directly by a high-order program address bit. The other two, called bank A and bank B here, are reached through a small bank register. Software loads that register with a write cycle to a fixed device-select code.

When the high address bit is low, fetches come from the lower page of the boot ROM. When it is high, they come from whichever banked ROM and page were last loaded into the register. A program-source gate input qualifies every enable. A two-bit strap input chooses the operating mode. Normal mode is for regular operation. Diagnostic mode exposes only the boot ROM's upper page, which holds the self-test program. Kill mode turns every ROM off so the processor can be tested on its own.

The enables are combinational in the address bit, gate and strap inputs. The bank register updates on the clock edge that samples the write.

Top module: `rom_bank_select`

## Requirements
- R1: When `dev_sel` equals 5 and `rd_wr` is high (1 = write) at a rising clock edge, the bank register takes `data_lo` at that edge, and the enables reflect the new value from then on.
- R2: At any edge where `dev_sel` is not 5, or `rd_wr` is low (read), the bank register keeps its value.
- R3: `data_lo[1]` picks the banked ROM: 1 selects bank A and 0 selects bank B. `data_lo[0]` picks the page: 1 selects the upper page and 0 selects the lower page.
- R4: In normal strap mode (`strap` = 00), while `addr_hi` is low and `src_gate` is high, the block enables only the boot ROM (`rom_en` = 001) with `page_sel` = 0. The boot ROM's upper page is never enabled in this mode.
- R5: In normal strap mode, while `addr_hi` is high and `src_gate` is high, the boot ROM is off. The latched ROM is enabled (bank A is `rom_en` = 010, bank B is `rom_en` = 100), and `page_sel` equals the latched page bit.
- R6: While `src_gate` is low, `rom_en` is 000 in every mode.
- R7: In diagnostic strap mode (`strap` = 01), the only possible enable is the boot ROM upper page (`rom_en` = 001 with `page_sel` = 1), given when `addr_hi` is low and `src_gate` is high. Banks A and B are never enabled in this mode.
- R8: In kill strap mode (`strap` = 10 or 11), `rom_en` is 000.
- R9: Reset (`rst_n` low) clears the bank register to bank B, lower page.
- R10: At most one bit of `rom_en` is high at a time, and `page_sel` is 0 whenever `rom_en` is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_sel | input | 4 | Device-select code from the processor |
| rd_wr | input | 1 | Bus direction, 1 = write |
| data_lo | input | 2 | Data bits 1 (bank) and 0 (page) |
| addr_hi | input | 1 | High program address bit: 0 = boot ROM, 1 = banked ROM |
| src_gate | input | 1 | Program-source gate; enables are only given while high |
| strap | input | 2 | Mode strap: 00 normal, 01 diagnostic, 10/11 kill |
| rom_en | output | 3 | ROM enables: bit 0 boot, bit 1 bank A, bit 2 bank B |
| page_sel | output | 1 | Page select for the enabled ROM, 1 = upper |

## Verification
A table of vectors loads each of the four bank and page combinations. Each vector then sweeps the address bit, the gate and all four strap codes. This separates the boot path from the banked path, separates a wrong bank bit from a wrong page bit, and shows that diagnostic and kill modes override the latched choice. Directed cases write with the select code on a read cycle and with a neighbouring code. These cases tell a register that holds apart from one that loads too eagerly. Another directed case checks the outputs just before and just after the capturing edge, which pins down the one-edge latency. A final case checks the reset value through the banked path.

// File: rtl/rsel_pkg.sv
package rsel_pkg;

  typedef enum logic [1:0] {
    STRAP_RUN   = 2'b00,
    STRAP_DIAG  = 2'b01,
    STRAP_KILL  = 2'b10,
    STRAP_KILL2 = 2'b11
  } strap_e;

  localparam int ROM_N    = 3;
  localparam int IDX_BOOT = 0;
  localparam int IDX_A    = 1;
  localparam int IDX_B    = 2;

  // Latched bank choice: pick_a = 1 selects bank A, upper = 1 selects upper page
  typedef struct packed {
    logic pick_a;
    logic upper;
  } bank_t;

  // Which fetch paths the strap mode allows
  typedef struct packed {
    logic boot_lo;
    logic boot_hi;
    logic banked;
  } permit_t;

  function automatic logic [ROM_N-1:0] rom_bit(input int idx);
    logic [ROM_N-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  function automatic bank_t bank_from_data(input logic [1:0] d);
    bank_t b;
    b.pick_a = d[1];
    b.upper  = d[0];
    return b;
  endfunction

endpackage

// File: rtl/rsel_bank_latch.sv
module rsel_bank_latch
  import rsel_pkg::*;
#(
  parameter int              SEL_W    = 4,
  parameter logic [SEL_W-1:0] SEL_CODE = SEL_W'(5)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] dev_sel,
  input  logic             rd_wr,
  input  logic [1:0]       data_lo,
  output bank_t            bank_q,
  output logic             wr_hit
);

  logic  dev_hit;
  bank_t bank_d;

  assign dev_hit = (dev_sel == SEL_CODE);
  assign wr_hit  = dev_hit && rd_wr;
  assign bank_d  = bank_from_data(data_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (wr_hit) begin
      bank_q <= bank_d;
    end
  end

  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (bank_q == bank_from_data($past(data_lo))));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(bank_q));

  assert_read_no_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_hit && !rd_wr) |=> $stable(bank_q));

endmodule

// File: rtl/rsel_strap_decode.sv
module rsel_strap_decode
  import rsel_pkg::*;
(
  input  strap_e  strap_mode,
  output permit_t permit
);

  always_comb begin
    permit = '0;
    unique case (strap_mode)
      STRAP_RUN: begin
        permit.boot_lo = 1'b1;
        permit.banked  = 1'b1;
      end
      STRAP_DIAG: begin
        permit.boot_hi = 1'b1;
      end
      STRAP_KILL, STRAP_KILL2: begin
        permit = '0;
      end
      default: permit = '0;
    endcase
  end

  always_comb begin
    assert_strap_excl_R7: assert (!(permit.boot_hi && (permit.boot_lo || permit.banked)));
  end

endmodule

// File: rtl/rsel_enable_decode.sv
module rsel_enable_decode
  import rsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  bank_t            bank_q,
  input  permit_t          permit,
  input  strap_e           strap_mode,
  input  logic             addr_hi,
  input  logic             src_gate,
  output logic [ROM_N-1:0] rom_en,
  output logic             page_sel
);

  logic boot_fetch;
  logic bank_fetch;

  assign boot_fetch = src_gate && !addr_hi && (permit.boot_lo || permit.boot_hi);
  assign bank_fetch = src_gate &&  addr_hi && permit.banked;

  always_comb begin
    rom_en   = '0;
    page_sel = 1'b0;
    if (boot_fetch) begin
      rom_en   = rom_bit(IDX_BOOT);
      page_sel = permit.boot_hi;
    end else if (bank_fetch) begin
      rom_en   = bank_q.pick_a ? rom_bit(IDX_A) : rom_bit(IDX_B);
      page_sel = bank_q.upper;
    end
  end

  assert_onehot_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rom_en));

  assert_page_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_en == '0) |-> !page_sel);

  assert_gate_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !src_gate |-> (rom_en == '0));

  assert_kill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_mode[1]) |-> (rom_en == '0));

  assert_boot_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_mode == STRAP_RUN && !addr_hi && rom_en[IDX_BOOT]) |-> !page_sel);

  assert_bank_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hi |-> (!rom_en[IDX_A] && !rom_en[IDX_B]));

  assert_boot_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hi |-> !rom_en[IDX_BOOT]);

  assert_diag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_mode == STRAP_DIAG && rom_en != '0) |-> (rom_en[IDX_BOOT] && page_sel));

endmodule

// File: rtl/rom_bank_select.sv
module rom_bank_select
  import rsel_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] dev_sel,
  input  logic             rd_wr,
  input  logic [1:0]       data_lo,
  input  logic             addr_hi,
  input  logic             src_gate,
  input  logic [1:0]       strap,
  output logic [ROM_N-1:0] rom_en,
  output logic             page_sel
);

  localparam logic [SEL_W-1:0] SEL_CODE = SEL_W'(5);

  strap_e  strap_mode;
  bank_t   bank_q;
  permit_t permit;
  logic    wr_hit;

  assign strap_mode = strap_e'(strap);

  rsel_bank_latch #(
    .SEL_W   (SEL_W),
    .SEL_CODE(SEL_CODE)
  ) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .dev_sel(dev_sel),
    .rd_wr  (rd_wr),
    .data_lo(data_lo),
    .bank_q (bank_q),
    .wr_hit (wr_hit)
  );

  rsel_strap_decode u_strap (
    .strap_mode(strap_mode),
    .permit    (permit)
  );

  rsel_enable_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_q    (bank_q),
    .permit    (permit),
    .strap_mode(strap_mode),
    .addr_hi   (addr_hi),
    .src_gate  (src_gate),
    .rom_en    (rom_en),
    .page_sel  (page_sel)
  );

  assert_reset_bank_R9: assert property (@(posedge clk)
    !rst_n |=> (bank_q == '0) || !rst_n || $past(wr_hit));

  assert_write_used_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && strap_mode == STRAP_RUN && addr_hi && src_gate) |=>
      ((strap_mode != STRAP_RUN) || !addr_hi || !src_gate ||
       (page_sel == $past(data_lo[0]) && rom_en[IDX_A] == $past(data_lo[1]))));

endmodule

// File: tb/rom_bank_select_tb_top.sv
module rom_bank_select_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] dev_sel;
  logic       rd_wr;
  logic [1:0] data_lo;
  logic       addr_hi;
  logic       src_gate;
  logic [1:0] strap;
  logic [2:0] rom_en;
  logic       page_sel;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  rom_bank_select dut_i (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .rd_wr(rd_wr),
    .data_lo(data_lo), .addr_hi(addr_hi), .src_gate(src_gate),
    .strap(strap), .rom_en(rom_en), .page_sel(page_sel)
  );

  // {strap, addr_hi, gate, bank_a, upper, exp_en[2:0], exp_page}
  localparam logic [9:0] VEC [16] = '{
    10'b00_0_1_1_1_001_0,
    10'b00_0_1_0_0_001_0,
    10'b00_1_1_1_0_010_0,
    10'b00_1_1_1_1_010_1,
    10'b00_1_1_0_0_100_0,
    10'b00_1_1_0_1_100_1,
    10'b00_1_0_1_1_000_0,
    10'b00_0_0_0_0_000_0,
    10'b01_0_1_1_1_001_1,
    10'b01_1_1_1_1_000_0,
    10'b01_0_0_0_0_000_0,
    10'b10_0_1_0_0_000_0,
    10'b10_1_1_1_1_000_0,
    10'b11_1_1_0_1_000_0,
    10'b11_0_1_0_0_000_0,
    10'b01_1_1_0_0_000_0
  };

  task automatic check(input logic [2:0] exp_en, input logic exp_pg, input string tag);
    checks++;
    if (rom_en !== exp_en || page_sel !== exp_pg) begin
      errors++;
      $display("FAIL %s: rom_en=%b page_sel=%b expected rom_en=%b page_sel=%b",
               tag, rom_en, page_sel, exp_en, exp_pg);
    end
  endtask

  task automatic write_bank(input logic [3:0] code, input logic wr, input logic [1:0] d);
    @(negedge clk);
    dev_sel = code; rd_wr = wr; data_lo = d;
    @(posedge clk);
    @(negedge clk);
    dev_sel = 4'd0; rd_wr = 1'b0; data_lo = ~d;
  endtask

  task automatic show_bank;
    strap = 2'b00; addr_hi = 1'b1; src_gate = 1'b1;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1: watchdog expired, actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dev_sel = 4'd5; rd_wr = 1'b1; data_lo = 2'b11;
    addr_hi = 1'b0; src_gate = 1'b1; strap = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check(3'b001, 1'b0, "R4 reset boot lower");
    dev_sel = 4'd0; rd_wr = 1'b0;
    rst_n = 1'b1;
    show_bank();
    check(3'b100, 1'b0, "R9 reset bank B lower");

    // Table sweep: R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < 16; i++) begin
      logic [9:0] v;
      v = VEC[i];
      write_bank(4'd5, 1'b1, {v[5], v[4]});
      strap = v[9:8]; addr_hi = v[7]; src_gate = v[6];
      #1;
      check(v[3:1], v[0], $sformatf("R3/R4/R5/R6/R7/R8/R10 vector %0d", i));
    end

    // R2: read cycle with the select code does not load
    write_bank(4'd5, 1'b1, 2'b11);
    write_bank(4'd5, 1'b0, 2'b00);
    show_bank();
    check(3'b010, 1'b1, "R2 read with select code");

    // R2: write with other codes does not load
    write_bank(4'd4, 1'b1, 2'b00);
    show_bank();
    check(3'b010, 1'b1, "R2 write code 4");
    write_bank(4'd13, 1'b1, 2'b00);
    show_bank();
    check(3'b010, 1'b1, "R2 write code 13");

    // R1: latency around the capturing edge
    write_bank(4'd5, 1'b1, 2'b00);
    show_bank();
    check(3'b100, 1'b0, "R1 bank B lower loaded");
    @(negedge clk);
    dev_sel = 4'd5; rd_wr = 1'b1; data_lo = 2'b11;
    #1;
    check(3'b100, 1'b0, "R1 before capturing edge");
    @(posedge clk);
    @(negedge clk);
    dev_sel = 4'd0; rd_wr = 1'b0; data_lo = 2'b00;
    #1;
    check(3'b010, 1'b1, "R1 after capturing edge");

    // R4: normal mode never shows boot upper page even with upper latched
    addr_hi = 1'b0;
    #1;
    check(3'b001, 1'b0, "R4 boot lower with upper latched");

    // R9: mid-run reset clears the latch
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    show_bank();
    check(3'b100, 1'b0, "R9 reset after use");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule